// File: doc/BRIEF.md
# Skewed Source Word Aligner

This block feeds a raster block-transfer engine with source words that are already shifted into the bit position of the destination. It holds a 32-bit shift buffer, reads 16-bit source words through a request/grant memory port, and for every destination word hands the sequencer one 16-bit word taken from the buffer at a programmable bit offset (the skew). The direction of travel across a line is the sign of the source X increment: a forward walk fills the buffer from the low side, a backward walk from the high side.

Each line may start with one extra priming read, so that the first destination word already sees two source words, and may end with the final read left out, when the last destination word needs nothing new. The aligner counts the source words left on the line, advances the source address by the X step after each read and by the Y step after the last read of the line, and reloads the count whenever the sequencer marks a word as the first of a line.

The sequencer holds `word_req` high with `word_first` / `word_last` set for the word in hand, waits for `src_valid`, consumes `src_word`, and pulses `word_adv` to move on. The aligner is busy, and the sequencer stalls, until every read it needs has been granted.

Top module: `src_aligner`

## Requirements
- R1: After reset `mem_req`, `src_valid` and `busy` are all low.
- R2: With a non-negative X increment (bit 15 of `cfg_xinc` clear), every buffer step shifts the 32-bit buffer left by 16 and a read word is placed in bits 15:0; `src_word` equals bits 15:0 of the buffer shifted right by `cfg_skew` (0..15).
- R3: With a negative X increment (bit 15 of `cfg_xinc` set), every buffer step shifts the buffer right by 16 and a read word is placed in bits 31:16.
- R4: For a word with `word_first` high while `cfg_prime` is set, one extra buffer step with a read is made before the normal step, so the word costs two reads.
- R5: For a word with `word_last` high while `cfg_nofinal` is set, the normal step shifts the buffer but issues no read.
- R6: The number of source words per line is `cfg_dst_words + cfg_prime - cfg_nofinal`; after each read the address moves by the sign-extended X increment, except after the read that finds one word left, which moves it by the Y increment instead.
- R7: Bit 0 of the loaded address and of both increments is treated as zero, so every `mem_addr` is even.
- R8: Once `src_valid` is high, further cycles of `word_req` cause no read and `src_word` stays unchanged until `word_adv`, after which `src_valid` is low.
- R9: While `mem_req` is high without `mem_gnt`, the request and `mem_addr` hold; `busy` is high whenever a word is being computed.
- R10: The source word counter reloads only when a word marked `word_first` starts, so each line repeats the same X/Y address pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_skew | input | 4 | Bit offset of the extracted word |
| cfg_prime | input | 1 | Extra read at the start of each line |
| cfg_nofinal | input | 1 | Omit the read of the last word of each line |
| cfg_xinc | input | 16 | Signed source step within a line |
| cfg_yinc | input | 16 | Signed source step from line end to next line |
| cfg_dst_words | input | 16 | Destination words per line (nonzero) |
| addr_load | input | 1 | Load `addr_in` as the source address |
| addr_in | input | 24 | Start source address |
| word_req | input | 1 | Sequencer needs the source word for the current destination word |
| word_first | input | 1 | Current word is the first of its line |
| word_last | input | 1 | Current word is the last of its line |
| word_adv | input | 1 | Current destination word done; drop the cached word |
| src_word | output | 16 | Aligned source word |
| src_valid | output | 1 | `src_word` holds the result for the current word |
| busy | output | 1 | Computation in progress |
| mem_req | output | 1 | Source read request |
| mem_addr | output | 24 | Source read address |
| mem_gnt | input | 1 | Read granted; data is taken this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_gnt` |

## Verification
The hardest case to reach is a one-word line with both the priming read and the omitted final read active, where the only read of the line also meets a count of one and must take the Y step, while the buffer still shifts a second time without a read. The bench reaches it with directed blits of a single word per line in both directions, and mixes in random blits whose grant is withheld for random cycles so that the same read has to stay stable across stalls.

// File: rtl/src_align_pkg.sv
package src_align_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PRIME = 2'd1,
      ST_MAIN  = 2'd2
   } aln_state_e;
endpackage

// File: rtl/aligner_shiftbuf.sv
// Two-word shift buffer with direction-dependent fill and skewed extraction.
module aligner_shiftbuf #(
   parameter int DATA_W = 16,
   parameter int SKW_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              fill_en,
   input  logic              dir_neg,
   input  logic [DATA_W-1:0] fill_data,
   input  logic [SKW_W-1:0]  skew,
   output logic [DATA_W-1:0] word_out
);
   localparam int BUF_W = 2 * DATA_W;

   if (DATA_W != (1 << SKW_W)) begin : g_bad_skew
      $error("aligner_shiftbuf: skew width must address every bit of a word");
   end

   logic [BUF_W-1:0] buf_q;
   logic [BUF_W-1:0] shifted;
   logic [BUF_W-1:0] placed;

   always_comb begin
      if (dir_neg) begin
         shifted = buf_q >> DATA_W;
         placed  = {fill_data, {DATA_W{1'b0}}};
      end else begin
         shifted = buf_q << DATA_W;
         placed  = {{DATA_W{1'b0}}, fill_data};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q <= '0;
      else if (step_en) buf_q <= shifted | (fill_en ? placed : '0);
   end

   logic [BUF_W-1:0] skewed;
   assign skewed   = buf_q >> skew;
   assign word_out = skewed[DATA_W-1:0];
endmodule

// File: rtl/aligner_addrgen.sv
// Source address and per-line word counter.
module aligner_addrgen #(
   parameter int ADDR_W = 24,
   parameter int INC_W  = 16,
   parameter int CNT_W  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [INC_W-1:0]  xinc,
   input  logic [INC_W-1:0]  yinc,
   input  logic              reload,
   input  logic [CNT_W-1:0]  reload_cnt,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   if (ADDR_W < 2 || INC_W < 2) begin : g_bad_w
      $error("aligner_addrgen: address and increment need at least two bits");
   end

   logic [ADDR_W-1:0] x_ext, y_ext;

   if (ADDR_W > INC_W) begin : g_sext
      assign x_ext = {{(ADDR_W-INC_W){xinc[INC_W-1]}}, xinc[INC_W-1:1], 1'b0};
      assign y_ext = {{(ADDR_W-INC_W){yinc[INC_W-1]}}, yinc[INC_W-1:1], 1'b0};
   end else begin : g_trunc
      assign x_ext = {xinc[ADDR_W-1:1], 1'b0};
      assign y_ext = {yinc[ADDR_W-1:1], 1'b0};
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;
   assign at_last = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         cnt_q <= '0;
      end else begin
         if (load)        addr <= {load_addr[ADDR_W-1:1], 1'b0};
         else if (step)   addr <= addr + (at_last ? y_ext : x_ext);
         if (reload)      cnt_q <= reload_cnt;
         else if (step && !at_last) cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/src_aligner.sv
module src_aligner #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int INC_W  = 16,
   parameter int WCNT_W = 16,
   parameter int SKW_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SKW_W-1:0]  cfg_skew,
   input  logic              cfg_prime,
   input  logic              cfg_nofinal,
   input  logic [INC_W-1:0]  cfg_xinc,
   input  logic [INC_W-1:0]  cfg_yinc,
   input  logic [WCNT_W-1:0] cfg_dst_words,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              word_req,
   input  logic              word_first,
   input  logic              word_last,
   input  logic              word_adv,
   output logic [DATA_W-1:0] src_word,
   output logic              src_valid,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata
);
   import src_align_pkg::*;

   localparam int CNT_W = WCNT_W + 1;

   aln_state_e st_q;
   logic       have_q;
   logic       skip_q;
   logic       start;
   logic       step_en, fill_en;
   logic [CNT_W-1:0] line_cnt;

   assign start    = (st_q == ST_IDLE) && word_req && !have_q;
   assign line_cnt = {1'b0, cfg_dst_words} + CNT_W'(cfg_prime) - CNT_W'(cfg_nofinal);

   always_comb begin
      mem_req = 1'b0;
      step_en = 1'b0;
      fill_en = 1'b0;
      unique case (st_q)
         ST_PRIME: begin
            mem_req = 1'b1;
            step_en = mem_gnt;
            fill_en = 1'b1;
         end
         ST_MAIN: begin
            mem_req = !skip_q;
            step_en = skip_q || mem_gnt;
            fill_en = !skip_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         have_q <= 1'b0;
         skip_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               skip_q <= word_last && cfg_nofinal;
               st_q   <= (word_first && cfg_prime) ? ST_PRIME : ST_MAIN;
            end
            ST_PRIME: if (mem_gnt) st_q <= ST_MAIN;
            ST_MAIN: if (step_en) begin
               st_q   <= ST_IDLE;
               have_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
         if (word_adv && have_q) have_q <= 1'b0;
      end
   end

   aligner_shiftbuf #(.DATA_W(DATA_W), .SKW_W(SKW_W)) i_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .fill_en  (fill_en),
      .dir_neg  (cfg_xinc[INC_W-1]),
      .fill_data(mem_rdata),
      .skew     (cfg_skew),
      .word_out (src_word)
   );

   aligner_addrgen #(.ADDR_W(ADDR_W), .INC_W(INC_W), .CNT_W(CNT_W)) i_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (addr_load),
      .load_addr (addr_in),
      .xinc      (cfg_xinc),
      .yinc      (cfg_yinc),
      .reload    (start && word_first),
      .reload_cnt(line_cnt),
      .step      (step_en && fill_en),
      .addr      (mem_addr)
   );

   assign src_valid = have_q;
   assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/src_aligner_chk.sv
module src_aligner_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              src_valid,
   input logic [DATA_W-1:0] src_word,
   input logic              word_adv,
   input logic              busy
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R9
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R9
   AST_NO_READ_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid |-> !mem_req && !busy); // R8
   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid && !word_adv |=> src_valid && $stable(src_word)); // R8
   AST_ADV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid && word_adv |=> !src_valid); // R8
   AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]); // R7
endmodule

bind src_aligner src_aligner_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
   .mem_addr(mem_addr), .src_valid(src_valid), .src_word(src_word),
   .word_adv(word_adv), .busy(busy)
);

// File: tb/test_src_aligner.sv
`timescale 1ns/1ps
module test_src_aligner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_skew = '0;
   logic        cfg_prime = 1'b0, cfg_nofinal = 1'b0;
   logic [15:0] cfg_xinc = '0, cfg_yinc = '0, cfg_dst_words = 16'd1;
   logic        addr_load = 1'b0;
   logic [23:0] addr_in = '0;
   logic        word_req = 1'b0, word_first = 1'b0, word_last = 1'b0, word_adv = 1'b0;
   logic [15:0] src_word;
   logic        src_valid, busy, mem_req, mem_gnt = 1'b0;
   logic [23:0] mem_addr;
   logic [15:0] mem_rdata;

   int n_chk = 0, n_fail = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   function automatic logic [15:0] mem_fn(input logic [23:0] a);
      logic [15:0] v;
      v = a[16:1] * 16'd40503;
      return v ^ 16'hC3A5 ^ {8'h00, a[23:16]};
   endfunction
   assign mem_rdata = mem_fn(mem_addr);

   src_aligner i_src_aligner (
      .clk(clk), .rst_n(rst_n), .cfg_skew(cfg_skew), .cfg_prime(cfg_prime),
      .cfg_nofinal(cfg_nofinal), .cfg_xinc(cfg_xinc), .cfg_yinc(cfg_yinc),
      .cfg_dst_words(cfg_dst_words), .addr_load(addr_load), .addr_in(addr_in),
      .word_req(word_req), .word_first(word_first), .word_last(word_last),
      .word_adv(word_adv), .src_word(src_word), .src_valid(src_valid), .busy(busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", cycles, 150000);
         finish_run();
      end
   end

   // reference state
   logic [31:0] m_buf = '0;
   logic [23:0] m_addr = '0;
   int          m_cnt = 0;

   function automatic logic [23:0] sx(input logic [15:0] v);
      return {{8{v[15]}}, v[15:1], 1'b0};
   endfunction

   task automatic m_step(input bit with_read, input logic [15:0] d);
      if (cfg_xinc[15]) begin
         m_buf = m_buf >> 16;
         if (with_read) m_buf = m_buf | {d, 16'h0000};
      end else begin
         m_buf = m_buf << 16;
         if (with_read) m_buf = m_buf | {16'h0000, d};
      end
      if (with_read) begin
         if (m_cnt == 1) m_addr = m_addr + sx(cfg_yinc);
         else begin m_cnt--; m_addr = m_addr + sx(cfg_xinc); end
      end
   endtask

   task automatic do_word(input bit first, input bit last, input int gnt_pct);
      int need, got, guard;
      bit skip;
      logic [15:0] exp_w, held;
      skip = last && cfg_nofinal;
      need = ((first && cfg_prime) ? 1 : 0) + (skip ? 0 : 1);
      if (first) m_cnt = cfg_dst_words + cfg_prime - cfg_nofinal; // R10
      got = 0; guard = 0;
      word_first = first; word_last = last; word_req = 1'b1;
      while (1) begin
         @(negedge clk);
         guard++;
         if (guard > 200) begin
            chk(0, "R9 word never completed", guard, 200);
            break;
         end
         if (src_valid) break;
         mem_gnt = 1'b0;
         if (mem_req && ($urandom_range(99) < gnt_pct)) begin
            mem_gnt = 1'b1;
            chk(mem_addr == m_addr, cfg_xinc[15] ? "R6 R3 read address" : "R6 R2 read address",
                {8'h0, mem_addr}, {8'h0, m_addr});
            m_step(1'b1, mem_fn(m_addr));
            got++;
         end
      end
      mem_gnt = 1'b0;
      if (skip) m_step(1'b0, 16'h0); // R5 shift without read
      chk(got == need, first && cfg_prime ? "R4 read count" : (skip ? "R5 read count" : "R6 read count"),
          got, need);
      exp_w = m_buf[cfg_skew +: 16];
      chk(src_word == exp_w, cfg_xinc[15] ? "R3 aligned word" : "R2 aligned word", {16'h0, src_word}, {16'h0, exp_w});
      held = src_word;
      // R8: keep requesting; no new read, word unchanged
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         chk(!mem_req && src_valid && src_word == held, "R8 cached word held",
             {15'h0, mem_req, src_word}, {16'h0, held});
      end
      word_req = 1'b0; word_adv = 1'b1;
      @(negedge clk);
      word_adv = 1'b0;
      chk(!src_valid, "R8 valid dropped after advance", src_valid, 0);
   endtask

   task automatic run_blit(input logic [3:0] sk, input bit pr, input bit nf,
                           input logic [15:0] xi, input logic [15:0] yi,
                           input int words, input int lines, input logic [23:0] a0,
                           input int gnt_pct);
      @(negedge clk);
      cfg_skew = sk; cfg_prime = pr; cfg_nofinal = nf; cfg_xinc = xi; cfg_yinc = yi;
      cfg_dst_words = 16'(words); addr_in = a0; addr_load = 1'b1;
      m_addr = {a0[23:1], 1'b0}; // R7 start address bit 0 dropped
      @(negedge clk);
      addr_load = 1'b0;
      for (int ln = 0; ln < lines; ln++)
         for (int w = 0; w < words; w++)
            do_word(w == 0, w == words - 1, gnt_pct);
   endtask

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      chk(!mem_req && !src_valid && !busy, "R1 reset state", {mem_req, src_valid, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !src_valid && !busy, "R1 idle after reset", {mem_req, src_valid, busy}, 0);

      // directed corners
      run_blit(4'd0,  1'b0, 1'b0, 16'h0002, 16'h0010, 3, 2, 24'h001000, 100); // R2 plain forward
      run_blit(4'd5,  1'b1, 1'b0, 16'h0002, 16'h0020, 3, 2, 24'h002001, 60);  // R4 R7 odd start
      run_blit(4'd15, 1'b0, 1'b1, 16'hFFFE, 16'hFFC0, 3, 2, 24'h003100, 60);  // R3 R5 backward
      run_blit(4'd9,  1'b1, 1'b1, 16'h0003, 16'h0041, 1, 3, 24'h004000, 50);  // R6 R7 single word both flags
      run_blit(4'd3,  1'b1, 1'b1, 16'hFFF9, 16'h0081, 1, 3, 24'h005000, 50);  // R3 single word both flags
      run_blit(4'd7,  1'b0, 1'b1, 16'h0002, 16'h0100, 1, 2, 24'h006000, 80);  // R5 no read at all
      run_blit(4'd12, 1'b1, 1'b0, 16'hFFFA, 16'h0200, 4, 3, 24'h007800, 20);  // R9 long stalls, R10

      // random blits
      for (int b = 0; b < 40; b++) begin
         logic [15:0] xi, yi;
         xi = 16'($urandom_range(15)) - 16'd7;
         yi = 16'($urandom_range(255)) - 16'd128;
         run_blit(4'($urandom_range(15)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                  xi, yi, $urandom_range(1, 5), $urandom_range(1, 3),
                  24'($urandom), $urandom_range(30, 100));
      end
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule